// File: doc/BRIEF.md
# Little-endian load/store lane unit

This unit sits between a processor core and a memory that is one 32-bit word wide. For every request it adds a 16-bit signed displacement to a base address to form the byte address. A store turns that address into a 4-bit byte-lane write-enable mask and places the register's low byte, low halfword or whole word into the lanes being written. A load takes the word the memory returns for that address and extracts the addressed byte, halfword or word. It then widens the value to 32 bits with the sign or with zeros, depending on the opcode.

The lane order is little-endian: the byte at the lowest address occupies the least significant bits of the word. A halfword or word access that does not fall on its natural boundary raises a fault flag in the same cycle. Such an access writes nothing and returns no load result. The memory read path is combinational toward the unit. The unit registers the extended load value, and the value appears one cycle after the request.

Top module: `lsu_lane_unit`

## Requirements
- R1: `memAddr` equals `baseAddr` plus `offset` sign-extended to 32 bits, in the same cycle as the request.
- R2: Opcode 0x28 (byte store) raises exactly one bit of `byteEn`, the one numbered by address bits [1:0]. That lane of `memWdata` holds `storeData[7:0]`.
- R3: Opcode 0x29 (halfword store) at an even address raises `byteEn` 4'b0011 when address bit 1 is 0, or 4'b1100 when it is 1. The two enabled lanes hold `storeData[15:0]`.
- R4: Opcode 0x2B (word store) at an address with bits [1:0] equal to 0 raises `byteEn` 4'b1111 and drives `memWdata` with `storeData`.
- R5: Lanes are little-endian: lane k is bits [8k+7:8k] of the memory word and holds the byte whose address has bits [1:0] equal to k. Storing word 0x00000005 at address 8 and then loading a byte from address 8 gives 5; loading a byte from address 11 gives 0.
- R6: Opcodes 0x20 (byte) and 0x21 (halfword) return the selected value sign-extended to 32 bits.
- R7: Opcodes 0x24 (byte) and 0x25 (halfword) return the selected value zero-extended to 32 bits.
- R8: Opcode 0x23 returns the whole addressed word unchanged.
- R9: An accepted load drives `loadValid` high for one cycle, one clock edge after the request, with the result on `loadData`.
- R10: A halfword access with address bit 0 set, or a word access with address bits [1:0] not zero, drives `misalign` high in the request cycle. The access then leaves `byteEn` at zero and produces no `loadValid`.
- R11: With `reqValid` low, or with an opcode outside the eight listed, `byteEn` is zero, `misalign` is zero and no `loadValid` follows.
- R12: While reset is held, `loadValid` and `loadData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| opcode | input | 6 | Load/store opcode |
| baseAddr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| storeData | input | 32 | Register value to store |
| memRdata | input | 32 | Word read from memory at `memAddr` |
| memAddr | output | 32 | Effective byte address |
| byteEn | output | 4 | Byte-lane write enables |
| memWdata | output | 32 | Lane-placed write data |
| misalign | output | 1 | Misaligned access flag |
| loadValid | output | 1 | Load result valid |
| loadData | output | 32 | Extended load result |

## Verification
The bench drives every access size at all four byte offsets against a behavioural word memory. A lane-index mistake would show up as a byte written to the wrong address. A reversed lane order would return the wrong byte on a load. The bench also checks sign versus zero extension with bytes and halfwords whose top bit is set, and extension logic swapped between opcodes would give wrong upper bits.

Misaligned stores are followed by word loads of the targeted location. A design that still wrote on a misaligned store would therefore return changed data. Misaligned and unknown-opcode loads must produce no result, because the scoreboard rejects any `loadValid` it does not expect. Negative displacements exercise sign extension of the offset.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [5:0] OP_LDB  = 6'h20;
  localparam logic [5:0] OP_LDH  = 6'h21;
  localparam logic [5:0] OP_LDW  = 6'h23;
  localparam logic [5:0] OP_LDBU = 6'h24;
  localparam logic [5:0] OP_LDHU = 6'h25;
  localparam logic [5:0] OP_STB  = 6'h28;
  localparam logic [5:0] OP_STH  = 6'h29;
  localparam logic [5:0] OP_STW  = 6'h2B;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef struct packed {
    logic     loadOk;
    logic     storeOk;
    logic     signExt;
    accSize_e size;
  } ctrlStrobes_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lsu_pkg::*;
(
  input  logic         reqValid,
  input  logic [5:0]   opcode,
  input  logic [1:0]   addrLow,
  output ctrlStrobes_t ctrl,
  output logic         misalign
);
  logic     isLoad, isStore, signExt, badAlign;
  accSize_e size;

  always_comb begin
    isLoad  = 1'b0;
    isStore = 1'b0;
    signExt = 1'b0;
    size    = SZ_WORD;
    case (opcode)
      OP_LDB:  begin isLoad = 1'b1; signExt = 1'b1; size = SZ_BYTE; end
      OP_LDBU: begin isLoad = 1'b1; size = SZ_BYTE; end
      OP_LDH:  begin isLoad = 1'b1; signExt = 1'b1; size = SZ_HALF; end
      OP_LDHU: begin isLoad = 1'b1; size = SZ_HALF; end
      OP_LDW:  begin isLoad = 1'b1; size = SZ_WORD; end
      OP_STB:  begin isStore = 1'b1; size = SZ_BYTE; end
      OP_STH:  begin isStore = 1'b1; size = SZ_HALF; end
      OP_STW:  begin isStore = 1'b1; size = SZ_WORD; end
      default: ;
    endcase
  end

  always_comb begin
    badAlign = ((size == SZ_HALF) && addrLow[0]) ||
               ((size == SZ_WORD) && (addrLow != 2'b00));
    misalign     = reqValid && (isLoad || isStore) && badAlign;
    ctrl.loadOk  = reqValid && isLoad  && !badAlign;
    ctrl.storeOk = reqValid && isStore && !badAlign;
    ctrl.signExt = signExt;
    ctrl.size    = size;
  end
endmodule

// File: rtl/lane_dp.sv
module lane_dp
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [OFF_W-1:0]    offset,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [DATA_W-1:0]   memRdata,
  input  ctrlStrobes_t        ctrl,
  output logic [ADDR_W-1:0]   effAddr,
  output logic [DATA_W/8-1:0] byteEn,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   loadWord
);
  localparam int LANES = DATA_W / 8;
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [1:0]        lane;
  logic [DATA_W-1:0] shifted;

  assign effAddr = baseAddr + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane    = effAddr[1:0];

  // Lane enables: one generated term per byte lane.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [1:0] LANE_ID = 2'(i);
    always_comb begin
      byteEn[i] = 1'b0;
      if (ctrl.storeOk) begin
        case (ctrl.size)
          SZ_BYTE: byteEn[i] = (lane == LANE_ID);
          SZ_HALF: byteEn[i] = (lane[1] == LANE_ID[1]);
          default: byteEn[i] = 1'b1;
        endcase
      end
    end
  end

  // Replicate the low part so it sits in whichever lane is enabled.
  always_comb begin
    case (ctrl.size)
      SZ_BYTE: wdata = {LANES{storeData[7:0]}};
      SZ_HALF: wdata = {(LANES/2){storeData[15:0]}};
      default: wdata = storeData;
    endcase
  end

  // Bring the addressed lane down to bit 0, then extend.
  always_comb begin
    shifted = memRdata >> {lane, 3'b000};
    case (ctrl.size)
      SZ_BYTE: loadWord = {{(DATA_W-8){ctrl.signExt & shifted[7]}}, shifted[7:0]};
      SZ_HALF: loadWord = {{(DATA_W-16){ctrl.signExt & shifted[15]}}, shifted[15:0]};
      default: loadWord = memRdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [5:0]          opcode,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [OFF_W-1:0]    offset,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] byteEn,
  output logic [DATA_W-1:0]   memWdata,
  output logic                misalign,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadData
);
  ctrlStrobes_t      ctrl;
  logic [DATA_W-1:0] loadWord;

  lane_ctrl u_ctrl (
    .reqValid (reqValid),
    .opcode   (opcode),
    .addrLow  (memAddr[1:0]),
    .ctrl     (ctrl),
    .misalign (misalign)
  );

  lane_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dp (
    .baseAddr  (baseAddr),
    .offset    (offset),
    .storeData (storeData),
    .memRdata  (memRdata),
    .ctrl      (ctrl),
    .effAddr   (memAddr),
    .byteEn    (byteEn),
    .wdata     (memWdata),
    .loadWord  (loadWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      loadData  <= '0;
    end else begin
      loadValid <= ctrl.loadOk;
      if (ctrl.loadOk) loadData <= loadWord;
    end
  end

  // R10: a flagged access never writes a lane
  p_misalign_nowrite_r10: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (byteEn == '0));

  // R2 R3 R4: only single lanes, aligned pairs or the full word are enabled
  p_lane_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteEn inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
                   4'b0011, 4'b1100, 4'b1111});

  // R9: a result only follows a request in the previous cycle
  p_result_after_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(reqValid));

  // R7: unsigned byte load leaves the upper 24 bits clear
  p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(opcode) == OP_LDBU) |-> (loadData[DATA_W-1:8] == '0));

  // R6: signed byte load has uniform upper bits
  p_sign_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && $past(opcode) == OP_LDB) |->
      ((loadData[DATA_W-1:7] == '0) || (loadData[DATA_W-1:7] == '1)));

  // R11: no request, no write
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> ((byteEn == '0) && !misalign));
endmodule

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [5:0]  opcode;
  logic [31:0] baseAddr;
  logic [15:0] offset;
  logic [31:0] storeData;
  logic [31:0] memRdata;
  logic [31:0] memAddr;
  logic [3:0]  byteEn;
  logic [31:0] memWdata;
  logic        misalign;
  logic        loadValid;
  logic [31:0] loadData;

  int checks = 0;
  int errors = 0;

  logic [31:0] memWords [64];
  logic [7:0]  refMem [256];

  logic [31:0] expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;

  lsu_lane_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
    .baseAddr(baseAddr), .offset(offset), .storeData(storeData),
    .memRdata(memRdata), .memAddr(memAddr), .byteEn(byteEn),
    .memWdata(memWdata), .misalign(misalign), .loadValid(loadValid),
    .loadData(loadData)
  );

  // Behavioural word memory
  assign memRdata = memWords[memAddr[7:2]];
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (byteEn[i]) memWords[memAddr[7:2]][i*8 +: 8] <= memWdata[i*8 +: 8];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rstN === 1'b1 && loadValid === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10/R11 unexpected loadValid", loadData, 32'h0);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(loadData === e, t, loadData, e);
      end
    end
  end

  function automatic logic [31:0] effOf(input logic [31:0] b, input logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  task automatic drive(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; opcode = op; baseAddr = b; offset = o; storeData = d;
    #1;
    check(memAddr === effOf(b, o), "R1 address", memAddr, effOf(b, o));
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; opcode = 6'h0;
  endtask

  task automatic doStore(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    logic [31:0] ea;
    logic [3:0]  expEn;
    logic        bad;
    string       t;
    ea = effOf(b, o);
    bad = 1'b0;
    case (op)
      6'h28: begin expEn = 4'b0001 << ea[1:0]; t = "R2 byte store lanes"; end
      6'h29: begin bad = ea[0]; expEn = bad ? 4'b0000 : (ea[1] ? 4'b1100 : 4'b0011); t = "R3 half store lanes"; end
      default: begin bad = (ea[1:0] != 2'b00); expEn = bad ? 4'b0000 : 4'b1111; t = "R4 word store lanes"; end
    endcase
    if (bad) t = "R10 misaligned store lanes";
    drive(op, b, o, d);
    check(byteEn === expEn, t, {28'h0, byteEn}, {28'h0, expEn});
    check(misalign === bad, "R10 misalign flag", {31'h0, misalign}, {31'h0, bad});
    if (!bad) begin
      case (op)
        6'h28: refMem[ea[7:0]] = d[7:0];
        6'h29: begin refMem[ea[7:0]] = d[7:0]; refMem[8'(ea[7:0] + 1)] = d[15:8]; end
        default: for (int k = 0; k < 4; k++) refMem[8'(ea[7:0] + k)] = d[k*8 +: 8];
      endcase
    end
    idle();
  endtask

  task automatic doLoad(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o, input string t);
    logic [31:0] ea, e;
    logic [7:0]  b0;
    logic [15:0] h;
    logic        bad;
    ea = effOf(b, o);
    b0 = refMem[ea[7:0]];
    h  = {refMem[8'(ea[7:0] + 1)], refMem[ea[7:0]]};
    bad = 1'b0;
    case (op)
      6'h20: e = {{24{b0[7]}}, b0};
      6'h24: e = {24'h0, b0};
      6'h21: begin e = {{16{h[15]}}, h}; bad = ea[0]; end
      6'h25: begin e = {16'h0, h}; bad = ea[0]; end
      default: begin
        e = {refMem[8'(ea[7:0] + 3)], refMem[8'(ea[7:0] + 2)], h};
        bad = (ea[1:0] != 2'b00);
      end
    endcase
    drive(op, b, o, 32'h0);
    check(misalign === bad, "R10 load misalign flag", {31'h0, misalign}, {31'h0, bad});
    check(byteEn === 4'b0000, "R11 load writes nothing", {28'h0, byteEn}, 32'h0);
    if (!bad) begin
      expQ.push_back(e);
      tagQ.push_back(t);
    end
    idle();
  endtask

  function automatic string loadTag(input logic [5:0] op);
    case (op)
      6'h20, 6'h21: return "R6 signed load";
      6'h24, 6'h25: return "R7 unsigned load";
      default:      return "R8 word load";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) memWords[i] = 32'h0;
    for (int i = 0; i < 256; i++) refMem[i] = 8'h0;
    rstN = 1'b0; reqValid = 1'b0; opcode = 6'h0; baseAddr = 32'h0;
    offset = 16'h0; storeData = 32'h0;
    repeat (3) @(negedge clk);
    check(loadValid === 1'b0, "R12 reset loadValid", {31'h0, loadValid}, 32'h0);
    check(loadData === 32'h0, "R12 reset loadData", loadData, 32'h0);
    check(byteEn === 4'b0000, "R11 idle byteEn", {28'h0, byteEn}, 32'h0);
    rstN = 1'b1;

    // R5: the little-endian example
    doStore(6'h2B, 32'h0, 16'd8, 32'h0000_0005);
    doLoad(6'h20, 32'h0, 16'd8,  "R5 byte at 8");
    doLoad(6'h20, 32'h0, 16'd11, "R5 byte at 11");

    // Fill words 1..31 with a negative offset (R1 sign extension)
    for (int w = 1; w < 32; w++)
      doStore(6'h2B, 32'h1000_0000 + w * 4 + 20, 16'hFFEC,
              32'h8A71_F3C4 ^ (w * 32'h0103_0507));

    // Every load size at every offset
    for (int w = 1; w < 9; w++)
      for (int k = 0; k < 4; k++) begin
        doLoad(6'h20, w * 4, 16'(k), loadTag(6'h20));
        doLoad(6'h24, w * 4, 16'(k), loadTag(6'h24));
        if (k[0] == 1'b0) begin
          doLoad(6'h21, w * 4, 16'(k), loadTag(6'h21));
          doLoad(6'h25, w * 4, 16'(k), loadTag(6'h25));
        end
        if (k == 0) doLoad(6'h23, w * 4, 16'(k), loadTag(6'h23));
      end

    // Byte stores at each lane, half stores at both halves, reread by word
    for (int k = 0; k < 4; k++)
      doStore(6'h28, 32'd80, 16'(k), 32'hFFFF_FF00 | (32'h81 + k * 17));
    doLoad(6'h23, 32'd80, 16'd0, "R2 R5 byte lanes by word");
    doStore(6'h29, 32'd84, 16'd0, 32'h1234_9ABC);
    doStore(6'h29, 32'd84, 16'd2, 32'hFFFF_7E01);
    doLoad(6'h23, 32'd84, 16'd0, "R3 half lanes by word");
    doLoad(6'h21, 32'd84, 16'd0, "R6 signed half");
    doLoad(6'h25, 32'd84, 16'd0, "R7 unsigned half");

    // Misaligned stores and loads: no write, no result
    doStore(6'h29, 32'd88, 16'd1, 32'hDEAD_BEEF);
    doStore(6'h29, 32'd88, 16'd3, 32'hDEAD_BEEF);
    for (int k = 1; k < 4; k++) doStore(6'h2B, 32'd92, 16'(k), 32'hCAFE_F00D);
    doLoad(6'h23, 32'd88, 16'd0, "R10 word unchanged after misaligned half");
    doLoad(6'h23, 32'd92, 16'd0, "R10 word unchanged after misaligned word");
    doLoad(6'h21, 32'd88, 16'd1, "R10 misaligned half load");
    doLoad(6'h23, 32'd88, 16'd2, "R10 misaligned word load");

    // Unknown opcodes and idle with a store opcode
    drive(6'h2A, 32'd96, 16'd0, 32'hFFFF_FFFF);
    check(byteEn === 4'b0000, "R11 unknown opcode byteEn", {28'h0, byteEn}, 32'h0);
    check(misalign === 1'b0, "R11 unknown opcode misalign", {31'h0, misalign}, 32'h0);
    drive(6'h22, 32'd97, 16'd0, 32'h0);
    check(misalign === 1'b0, "R11 unknown load opcode", {31'h0, misalign}, 32'h0);
    @(negedge clk);
    reqValid = 1'b0; opcode = 6'h2B; baseAddr = 32'd96; storeData = 32'hFFFF_FFFF;
    #1;
    check(byteEn === 4'b0000, "R11 no request byteEn", {28'h0, byteEn}, 32'h0);
    idle();
    doLoad(6'h23, 32'd96, 16'd0, "R11 word untouched");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9 all results returned", expQ.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule